// File: doc/BRIEF.md
# Four-Lane Link Test Pattern Generator

This block drives fixed, predictable test words onto four 16-bit lanes that feed a multi-gigabit serial link, one word per lane on every user clock. Two lanes carry constant words and two carry counting ramps, one rising and one falling. A receiver that knows these patterns can detect a lost, repeated or corrupted word on any lane.

The block also models the link's periodic resynchronisation. At a fixed interval the valid flags of all lanes drop for a short burst. While valid is low neither ramp moves, so the receiver sees an unbroken count across the gap. The rising ramp is also copied to a separate monitor port, which stands in for a converter that shows the count to an outside observer.

Lane positions are fixed. Lane i occupies bits [16*i+15 : 16*i] of the packed data bus. The order, from lane 0, is: constant 0xAAAA, rising ramp, constant 0xCCCC, falling ramp.

Top module: `lane_pattern_gen`

## Requirements
- R1: While rst_n is low, lane 1 reads 0x0000, lane 3 reads 0xFFFF, the monitor reads 0x0000 and all four valid bits are 1.
- R2: Lane 0 (bits 15:0) always reads 0xAAAA, and lane 2 (bits 47:32) always reads 0xCCCC, including during a resync gap.
- R3: Lane 1 (bits 31:16) is a rising ramp. After every cycle in which valid is high, it is one greater than before.
- R4: Lane 3 (bits 63:48) is a falling ramp. After every cycle in which valid is high, it is one less than before, so it always equals 0xFFFF minus lane 1.
- R5: Counting from the first clock cycle after reset is released as cycle 0, a resync gap starts at cycle 4992 and at every later multiple of 4992.
- R6: Each resync gap lasts 6 cycles. During it, all valid bits are 0. At all other times they are 1.
- R7: Neither ramp changes during a cycle in which valid is low.
- R8: Both ramps wrap modulo 2^16. The rising ramp goes from 0xFFFF to 0x0000, and the falling ramp goes from 0x0000 to 0xFFFF.
- R9: The monitor output equals lane 1 in every cycle.
- R10: The four valid bits are always equal to each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock; one word per lane per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| lane_data_o | output | 64 | Packed lane words; lane i at bits [16*i+15:16*i] |
| lane_vld_o | output | 4 | Per-lane valid; bit i belongs to lane i |
| mon_ramp_o | output | 16 | Copy of the rising ramp for an external monitor |

## Verification
The only input besides the clock is reset. The assertions therefore take for granted that rst_n is released in step with clk, and that the block then runs freely with no other disturbance. The interval and gap-length checks also assume that the valid run counters restart at each reset.

The stimulus releases reset one time unit after a rising edge. It runs past the 16-bit wrap of both ramps. It then asserts reset again in the middle of a gap, to show that the interval timer restarts from zero. Every cycle is compared with a closed-form count of the valid cycles that precede it.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  // Pattern carried by a lane; lane order is fixed by index.
  typedef enum logic [1:0] {
    LK_CONST_A = 2'd0,
    LK_RAMP_UP = 2'd1,
    LK_CONST_B = 2'd2,
    LK_RAMP_DN = 2'd3
  } lane_kind_e;

  function automatic lane_kind_e kind_of(input int unsigned idx);
    case (idx % 4)
      0:       kind_of = LK_CONST_A;
      1:       kind_of = LK_RAMP_UP;
      2:       kind_of = LK_CONST_B;
      default: kind_of = LK_RAMP_DN;
    endcase
  endfunction

endpackage

// File: rtl/lpg_resync_timer.sv
module lpg_resync_timer #(
  parameter int PERIOD = 4992,
  parameter int GAP    = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic gap_o
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] GLIM = PW'(GAP);

  logic [PW-1:0] phase_q, phase_d;
  logic          armed_q, armed_d;
  logic          wrap;

  assign wrap = (phase_q == LAST);

  always_comb begin
    phase_d = wrap ? '0 : phase_q + 1'b1;
    armed_d = armed_q | wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      armed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      armed_q <= armed_d;
    end
  end

  // No gap before the first full interval has elapsed.
  assign gap_o = armed_q && (phase_q < GLIM);

endmodule

// File: rtl/lpg_ramp.sv
module lpg_ramp #(
  parameter int WIDTH = 16,
  parameter bit DOWN  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  output logic [WIDTH-1:0] value_o
);
  localparam logic [WIDTH-1:0] START = DOWN ? {WIDTH{1'b1}} : '0;

  logic [WIDTH-1:0] cnt_q, cnt_d, stepped;

  generate
    if (DOWN) begin : g_down
      assign stepped = cnt_q - WIDTH'(1);
    end else begin : g_up
      assign stepped = cnt_q + WIDTH'(1);
    end
  endgenerate

  always_comb begin
    cnt_d = step_en ? stepped : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= START;
    else        cnt_q <= cnt_d;
  end

  assign value_o = cnt_q;

endmodule

// File: rtl/lpg_lane_mux.sv
module lpg_lane_mux
  import lpg_pkg::*;
#(
  parameter int              NUM_LANES = 4,
  parameter int              WIDTH     = 16,
  parameter logic [WIDTH-1:0] CONST_A  = 16'hAAAA,
  parameter logic [WIDTH-1:0] CONST_B  = 16'hCCCC
) (
  input  logic [WIDTH-1:0]           up_i,
  input  logic [WIDTH-1:0]           dn_i,
  input  logic                       valid_i,
  output logic [NUM_LANES*WIDTH-1:0] data_o,
  output logic [NUM_LANES-1:0]       vld_o
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam lane_kind_e K = kind_of(i);
    if (K == LK_CONST_A) begin : g_ca
      assign data_o[i*WIDTH +: WIDTH] = CONST_A;
    end else if (K == LK_RAMP_UP) begin : g_up
      assign data_o[i*WIDTH +: WIDTH] = up_i;
    end else if (K == LK_CONST_B) begin : g_cb
      assign data_o[i*WIDTH +: WIDTH] = CONST_B;
    end else begin : g_dn
      assign data_o[i*WIDTH +: WIDTH] = dn_i;
    end
    assign vld_o[i] = valid_i;
  end

endmodule

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen #(
  parameter int               NUM_LANES     = 4,
  parameter int               WORD_W        = 16,
  parameter int               RESYNC_PERIOD = 4992,
  parameter int               RESYNC_LEN    = 6,
  parameter logic [WORD_W-1:0] CONST_A      = 16'hAAAA,
  parameter logic [WORD_W-1:0] CONST_B      = 16'hCCCC
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic [NUM_LANES*WORD_W-1:0] lane_data_o,
  output logic [NUM_LANES-1:0]        lane_vld_o,
  output logic [WORD_W-1:0]           mon_ramp_o
);
  logic             in_gap;
  logic             xfer_en;
  logic [WORD_W-1:0] up_val, dn_val;

  lpg_resync_timer #(
    .PERIOD (RESYNC_PERIOD),
    .GAP    (RESYNC_LEN)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .gap_o (in_gap)
  );

  // A word is transferred on every cycle outside the gap.
  assign xfer_en = ~in_gap;

  lpg_ramp #(.WIDTH(WORD_W), .DOWN(1'b0)) u_ramp_up (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (xfer_en),
    .value_o (up_val)
  );

  lpg_ramp #(.WIDTH(WORD_W), .DOWN(1'b1)) u_ramp_dn (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (xfer_en),
    .value_o (dn_val)
  );

  lpg_lane_mux #(
    .NUM_LANES (NUM_LANES),
    .WIDTH     (WORD_W),
    .CONST_A   (CONST_A),
    .CONST_B   (CONST_B)
  ) u_mux (
    .up_i    (up_val),
    .dn_i    (dn_val),
    .valid_i (xfer_en),
    .data_o  (lane_data_o),
    .vld_o   (lane_vld_o)
  );

  assign mon_ramp_o = up_val;

endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int               NUM_LANES     = 4,
  parameter int               WORD_W        = 16,
  parameter int               RESYNC_PERIOD = 4992,
  parameter int               RESYNC_LEN    = 6,
  parameter logic [WORD_W-1:0] CONST_A      = 16'hAAAA,
  parameter logic [WORD_W-1:0] CONST_B      = 16'hCCCC
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_LANES*WORD_W-1:0] lane_data_o,
  input logic [NUM_LANES-1:0]        lane_vld_o,
  input logic [WORD_W-1:0]           mon_ramp_o
);
  logic [WORD_W-1:0] l0, l1, l2, l3;
  logic              v;
  logic [31:0]       vrun, grun;

  assign l0 = lane_data_o[0*WORD_W +: WORD_W];
  assign l1 = lane_data_o[1*WORD_W +: WORD_W];
  assign l2 = lane_data_o[2*WORD_W +: WORD_W];
  assign l3 = lane_data_o[3*WORD_W +: WORD_W];
  assign v  = lane_vld_o[0];

  // Run-length counters for valid and gap stretches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vrun <= '0;
      grun <= '0;
    end else begin
      vrun <= v ? vrun + 1 : '0;
      grun <= v ? '0 : grun + 1;
    end
  end

  a_r2_const_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (l0 == CONST_A) && (l2 == CONST_B));
  a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    v |=> (l1 == $past(l1) + WORD_W'(1)));
  a_r4_dn_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (l3 == ~l1));
  a_r5_interval: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v) |-> (vrun == 32'(RESYNC_PERIOD) || vrun == 32'(RESYNC_PERIOD - RESYNC_LEN)));
  a_r6_gap_short: assert property (@(posedge clk) disable iff (!rst_n)
    !v |-> (grun < 32'(RESYNC_LEN)));
  a_r6_gap_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v) |-> (grun == 32'(RESYNC_LEN)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v |=> ($stable(l1) && $stable(l3)));
  a_r9_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    mon_ramp_o == l1);
  a_r10_uniform_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lane_vld_o) == 0) || ($countones(lane_vld_o) == NUM_LANES));

endmodule

bind lane_pattern_gen lpg_checker #(
  .NUM_LANES     (NUM_LANES),
  .WORD_W        (WORD_W),
  .RESYNC_PERIOD (RESYNC_PERIOD),
  .RESYNC_LEN    (RESYNC_LEN),
  .CONST_A       (CONST_A),
  .CONST_B       (CONST_B)
) u_lpg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lane_data_o (lane_data_o),
  .lane_vld_o  (lane_vld_o),
  .mon_ramp_o  (mon_ramp_o)
);

// File: tb/lane_pattern_gen_test.sv
module lane_pattern_gen_test;
  localparam int W   = 16;
  localparam int NL  = 4;
  localparam int PER = 4992;
  localparam int GL  = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [NL*W-1:0]   lane_data;
  logic [NL-1:0]     lane_vld;
  logic [W-1:0]      mon;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  lane_pattern_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_data_o (lane_data),
    .lane_vld_o  (lane_vld),
    .mon_ramp_o  (mon)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  // Gap cycles strictly before cycle n.
  function automatic int unsigned gaps_before(input int unsigned n);
    int unsigned k;
    if (n <= PER) return 0;
    k = n - PER;
    return (k / PER) * GL + (((k % PER) < GL) ? (k % PER) : GL);
  endfunction

  function automatic bit is_gap(input int unsigned n);
    return (n >= PER) && ((n % PER) < GL);
  endfunction

  task automatic reset_checks();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp("R1 up at reset", lane_data[1*W +: W], 16'h0000);
      cmp("R1 dn at reset", lane_data[3*W +: W], 16'hFFFF);
      cmp("R1 valid at reset", W'(lane_vld), W'(4'hF));
      cmp("R1 monitor at reset", mon, 16'h0000);
    end
  endtask

  task automatic run_span(input int unsigned cycles);
    for (int unsigned n = 0; n < cycles; n++) begin
      logic [W-1:0] eu, ed;
      bit g;
      @(negedge clk);
      g  = is_gap(n);
      eu = W'(n - gaps_before(n));
      ed = ~eu;
      cmp("R2 lane0 const", lane_data[0*W +: W], 16'hAAAA);
      cmp("R2 lane2 const", lane_data[2*W +: W], 16'hCCCC);
      if (g)                     cmp("R7 up holds in gap", lane_data[1*W +: W], eu);
      else if (eu == 0 && n > 0) cmp("R8 up wraps", lane_data[1*W +: W], eu);
      else                       cmp("R3 up ramp", lane_data[1*W +: W], eu);
      if (g)                         cmp("R7 dn holds in gap", lane_data[3*W +: W], ed);
      else if (ed == 16'hFFFF && n > 0) cmp("R8 dn wraps", lane_data[3*W +: W], ed);
      else                           cmp("R4 dn ramp", lane_data[3*W +: W], ed);
      if (g) cmp("R6 valid low in gap", W'(lane_vld), W'(4'h0));
      else   cmp("R5 valid outside gap", W'(lane_vld), W'(4'hF));
      check((lane_vld == 4'h0) || (lane_vld == 4'hF), "R10 valid bits equal",
            W'(lane_vld), W'(lane_vld[0] ? 4'hF : 4'h0));
      cmp("R9 monitor", mon, eu);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    reset_checks();
    @(posedge clk); #1 rst_n = 1'b1;
    // Past the 16-bit wrap; ends two cycles into a gap.
    run_span(14 * PER + 3);
    @(posedge clk); #1 rst_n = 1'b0;
    reset_checks();
    @(posedge clk); #1 rst_n = 1'b1;
    // Interval must restart from zero after the mid-gap reset (R5).
    run_span(2 * PER + GL + 4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule